// File: doc/BRIEF.md
# Cross-Coupled Parity Routing Self-Test

This block is a built-in self-test for interconnect. Its generator side drives a bundle of nets under test. The bench or the surrounding fabric routes that bundle back into the block's analyzer side. Two small pattern counters share a clock, a reset and an enable, and they advance together. One counts upward from zero and the other counts downward from all-ones. Each counter publishes its state bits and one parity bit. The upward counter uses even parity and the downward counter uses odd parity.

The nets are split into two lanes, one per counter. Each lane carries the counter's state, the counter's own parity, and a copy of the other counter's parity. The analyzer on each lane checks the received state against both parity bits. No expected values are stored. Because each analyzer depends on the opposite generator for one of its checks, a fault in either generator is exposed as well as a fault on a wire.

Any mismatch sets a sticky fault flag for that lane. Only reset clears it. Comparison begins after a short settling window that follows the release of reset. The window lets the routed nets propagate. Comparison then runs on every cycle in which enable is high.

Top module: `xparity_route_tester`

## Requirements
- R1: While reset is asserted, `netTx` reads 8'h78 (up state 0, down state 3) and both fault flags are 0.
- R2: On each clock edge with `enable` high, the up state in `netTx[1:0]` increases by one modulo 4 and the down state in `netTx[5:4]` decreases by one modulo 4.
- R3: The down state is always the bitwise complement of the up state, so the two states sum to 3.
- R4: `netTx[2]` is the even parity of the up state and `netTx[6]` is the odd parity of the down state. `netTx[7]` repeats `netTx[2]` and `netTx[3]` repeats `netTx[6]`.
- R5: Lane A is `netRx[3:0]` (data `[1:0]`, own parity `[2]`, cross parity `[3]`) and drives `faultUp`. Lane B is `netRx[7:4]` (data `[5:4]`, own parity `[6]`, cross parity `[7]`) and drives `faultDown`.
- R6: On the first clock edge after reset is released, no comparison is made, so a bad `netRx` leaves both flags clear.
- R7: After the settling window, on an edge with `enable` high, lane A flags a fault when XOR(data, own) is not 0 or XOR(data, cross) is not 1. Lane B flags a fault when XOR(data, own) is not 1 or XOR(data, cross) is not 0. The flag is visible after that edge.
- R8: A set fault flag stays set until reset, even after `netRx` becomes correct again.
- R9: With `enable` low, `netTx` holds its value and neither flag changes, whatever `netRx` carries.
- R10: With no faults, every bit of `netTx` takes both the value 0 and the value 1 within four enabled cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by generators and analyzers |
| rstN | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Advances the counters and allows comparison |
| netRx | input | 8 | Bundle received back from the nets under test |
| netTx | output | 8 | Bundle driven onto the nets under test |
| faultUp | output | 1 | Sticky fault flag of lane A |
| faultDown | output | 1 | Sticky fault flag of lane B |

## Verification
The bench runs three kinds of return paths. A clean loopback shows that the patterns toggle every net and that neither flag rises on its own. A stuck-at-0 and a stuck-at-1 are forced on each of the eight nets in turn, and each must raise a flag. This shows that the wires and both generators' parity outputs are covered. Wired-AND and wired-OR shorts are applied between every pair of nets and compared cycle by cycle against a behavioural model. Together with runs that hold `enable` low and runs that clear a fault after it was flagged, they separate the settling window, the hold behaviour and the sticky flag from the parity check itself.

// File: rtl/xprt_pkg.sv
package xprt_pkg;

  // Strobes from the control to the datapath
  typedef struct packed {
    logic step;   // advance both pattern counters
    logic check;  // analyzers compare this cycle
  } ctrlStrobe_t;

  // Nets per lane: state bits, own parity, cross parity
  function automatic int laneWidth(input int cntW);
    return cntW + 2;
  endfunction

endpackage

// File: rtl/xprt_ctrl.sv
module xprt_ctrl
  import xprt_pkg::*;
#(
  parameter int SETTLE_CYCLES = 1
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        enable,
  output ctrlStrobe_t strobe
);

  localparam int SW = (SETTLE_CYCLES > 0) ? $clog2(SETTLE_CYCLES + 1) : 1;
  localparam logic [SW-1:0] SETTLE_LIMIT = SW'(SETTLE_CYCLES);

  logic [SW-1:0] settleCnt;
  logic          armed;

  assign armed = (settleCnt == SETTLE_LIMIT);

  // Counts edges after reset release; stops at the limit
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      settleCnt <= '0;
    end else if (!armed) begin
      settleCnt <= settleCnt + SW'(1);
    end
  end

  always_comb begin
    strobe.step  = enable;
    strobe.check = enable & armed;
  end

endmodule

// File: rtl/xprt_pattern_gen.sv
module xprt_pattern_gen #(
  parameter int CNT_W      = 2,
  parameter bit COUNT_DOWN = 1'b0,
  parameter bit ODD_PAR    = 1'b0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             step,
  output logic [CNT_W-1:0] state,
  output logic             parity
);

  localparam logic [CNT_W-1:0] START = COUNT_DOWN ? '1 : '0;

  logic [CNT_W-1:0] nextState;

  generate
    if (COUNT_DOWN) begin : g_down
      assign nextState = state - CNT_W'(1);
    end else begin : g_up
      assign nextState = state + CNT_W'(1);
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= START;
    end else if (step) begin
      state <= nextState;
    end
  end

  assign parity = (^state) ^ ODD_PAR;

endmodule

// File: rtl/xprt_analyzer.sv
module xprt_analyzer #(
  parameter int CNT_W     = 2,
  parameter bit OWN_EXP   = 1'b0,
  parameter bit CROSS_EXP = 1'b1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             check,
  input  logic [CNT_W-1:0] rxData,
  input  logic             rxOwnPar,
  input  logic             rxCrossPar,
  output logic             faultFlag
);

  logic dataPar;
  logic ownBad;
  logic crossBad;

  assign dataPar  = ^rxData;
  assign ownBad   = (dataPar ^ rxOwnPar) != OWN_EXP;
  assign crossBad = (dataPar ^ rxCrossPar) != CROSS_EXP;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      faultFlag <= 1'b0;
    end else if (check && (ownBad || crossBad)) begin
      faultFlag <= 1'b1;
    end
  end

endmodule

// File: rtl/xprt_datapath.sv
module xprt_datapath
  import xprt_pkg::*;
#(
  parameter int CNT_W = 2
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  ctrlStrobe_t                    strobe,
  input  logic [2*laneWidth(CNT_W)-1:0]  netRx,
  output logic [2*laneWidth(CNT_W)-1:0]  netTx,
  output logic [1:0]                     laneFault
);

  localparam int LANE_W = laneWidth(CNT_W);
  // Complementing an odd number of bits flips parity
  localparam bit FLIP = CNT_W[0];

  logic [1:0][CNT_W-1:0] laneState;
  logic [1:0]            laneParity;

  // Lane 0: up counter, even parity. Lane 1: down counter, odd parity.
  generate
    for (genvar g = 0; g < 2; g++) begin : g_lane
      localparam int BASE = g * LANE_W;

      xprt_pattern_gen #(
        .CNT_W      (CNT_W),
        .COUNT_DOWN (g == 1),
        .ODD_PAR    (g == 1)
      ) u_gen (
        .clk    (clk),
        .rstN   (rstN),
        .step   (strobe.step),
        .state  (laneState[g]),
        .parity (laneParity[g])
      );

      assign netTx[BASE +: CNT_W]    = laneState[g];
      assign netTx[BASE + CNT_W]     = laneParity[g];
      assign netTx[BASE + CNT_W + 1] = laneParity[1-g];

      xprt_analyzer #(
        .CNT_W     (CNT_W),
        .OWN_EXP   (g == 1),
        .CROSS_EXP ((g == 0) ^ FLIP)
      ) u_ana (
        .clk        (clk),
        .rstN       (rstN),
        .check      (strobe.check),
        .rxData     (netRx[BASE +: CNT_W]),
        .rxOwnPar   (netRx[BASE + CNT_W]),
        .rxCrossPar (netRx[BASE + CNT_W + 1]),
        .faultFlag  (laneFault[g])
      );
    end
  endgenerate

endmodule

// File: rtl/xparity_route_tester.sv
module xparity_route_tester
  import xprt_pkg::*;
#(
  parameter int CNT_W         = 2,
  parameter int SETTLE_CYCLES = 1
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    enable,
  input  logic [2*(CNT_W+2)-1:0]  netRx,
  output logic [2*(CNT_W+2)-1:0]  netTx,
  output logic                    faultUp,
  output logic                    faultDown
);

  ctrlStrobe_t strobe;
  logic [1:0]  laneFault;

  xprt_ctrl #(
    .SETTLE_CYCLES (SETTLE_CYCLES)
  ) u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .enable (enable),
    .strobe (strobe)
  );

  xprt_datapath #(
    .CNT_W (CNT_W)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .netRx     (netRx),
    .netTx     (netTx),
    .laneFault (laneFault)
  );

  assign faultUp   = laneFault[0];
  assign faultDown = laneFault[1];

endmodule

// File: rtl/xprt_checker.sv
module xprt_checker #(
  parameter int CNT_W         = 2,
  parameter int SETTLE_CYCLES = 1
) (
  input logic                   clk,
  input logic                   rstN,
  input logic                   enable,
  input logic [2*(CNT_W+2)-1:0] netTx,
  input logic                   faultUp,
  input logic                   faultDown
);

  localparam int L = CNT_W + 2;

  logic [CNT_W-1:0] upData;
  logic [CNT_W-1:0] dnData;
  assign upData = netTx[CNT_W-1:0];
  assign dnData = netTx[L +: CNT_W];

  // Edges since reset release, saturating at the settle window
  int sinceRst;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) sinceRst <= 0;
    else if (sinceRst < SETTLE_CYCLES) sinceRst <= sinceRst + 1;
  end

  assert_up_step_R2: assert property (@(posedge clk) disable iff (!rstN)
    enable |=> upData == $past(upData) + CNT_W'(1));

  assert_down_step_R2: assert property (@(posedge clk) disable iff (!rstN)
    enable |=> dnData == $past(dnData) - CNT_W'(1));

  assert_complement_R3: assert property (@(posedge clk) disable iff (!rstN)
    dnData == ~upData);

  assert_parity_copies_R4: assert property (@(posedge clk) disable iff (!rstN)
    (netTx[2*L-1] == netTx[CNT_W]) && (netTx[CNT_W+1] == netTx[L+CNT_W]));

  assert_parity_sense_R4: assert property (@(posedge clk) disable iff (!rstN)
    ((^{upData, netTx[CNT_W]}) == 1'b0) && ((^{dnData, netTx[L+CNT_W]}) == 1'b1));

  assert_settle_quiet_R6: assert property (@(posedge clk) disable iff (!rstN)
    (sinceRst < SETTLE_CYCLES) |=> (!faultUp && !faultDown));

  assert_sticky_up_R8: assert property (@(posedge clk) disable iff (!rstN)
    faultUp |=> faultUp);

  assert_sticky_down_R8: assert property (@(posedge clk) disable iff (!rstN)
    faultDown |=> faultDown);

  assert_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> $stable(netTx) && $stable(faultUp) && $stable(faultDown));

endmodule

bind xparity_route_tester xprt_checker #(
  .CNT_W         (CNT_W),
  .SETTLE_CYCLES (SETTLE_CYCLES)
) u_chk (.*);

// File: tb/test_xparity_route_tester.sv
module test_xparity_route_tester;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       enable = 1'b0;
  logic [7:0] netRx;
  logic [7:0] netTx;
  logic       faultUp;
  logic       faultDown;

  int total = 0;
  int bad   = 0;

  // Fault injection: 0 none, 1 stuck-0, 2 stuck-1, 3 wired-AND, 4 wired-OR
  int fMode = 0;
  int fA = 0;
  int fB = 1;

  always #2 clk = ~clk;  // 250 MHz

  function automatic logic [7:0] applyFault(input logic [7:0] v, input int mode,
                                            input int a, input int b);
    logic [7:0] r;
    logic t;
    r = v;
    case (mode)
      1: r[a] = 1'b0;
      2: r[a] = 1'b1;
      3: begin t = v[a] & v[b]; r[a] = t; r[b] = t; end
      4: begin t = v[a] | v[b]; r[a] = t; r[b] = t; end
      default: ;
    endcase
    return r;
  endfunction

  // Expected drive bundle for up count u and down count d
  function automatic logic [7:0] modelTx(input int u, input int d);
    logic [1:0] ub;
    logic [1:0] db;
    logic upP;
    logic dnP;
    ub = u[1:0];
    db = d[1:0];
    upP = ub[0] ^ ub[1];
    dnP = ~(db[0] ^ db[1]);
    return {upP, dnP, db, dnP, upP, ub};
  endfunction

  assign netRx = applyFault(netTx, fMode, fA, fB);

  xparity_route_tester i_xparity_route_tester (
    .clk       (clk),
    .rstN      (rstN),
    .enable    (enable),
    .netRx     (netRx),
    .netTx     (netTx),
    .faultUp   (faultUp),
    .faultDown (faultDown)
  );

  // Behavioural reference model
  int   mUp, mDown, mEdges;
  logic mFlagA, mFlagB;

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mUp = 0; mDown = 3; mEdges = 0; mFlagA = 1'b0; mFlagB = 1'b0;
    end else begin
      logic [7:0] rx;
      int pa, pb;
      rx = applyFault(modelTx(mUp, mDown), fMode, fA, fB);
      if (mEdges >= 1 && enable) begin
        pa = rx[0] ^ rx[1];
        pb = rx[4] ^ rx[5];
        if (((pa ^ rx[2]) != 0) || ((pa ^ rx[3]) != 1)) mFlagA = 1'b1;
        if (((pb ^ rx[6]) != 1) || ((pb ^ rx[7]) != 0)) mFlagB = 1'b1;
      end
      if (enable) begin
        mUp = (mUp + 1) % 4;
        mDown = (mDown + 3) % 4;
      end
      mEdges++;
    end
  end

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Advance one cycle and compare against the model at the falling edge
  task automatic cycle();
    @(negedge clk);
    check("R2 R3 R4 R5 netTx", netTx, modelTx(mUp, mDown));
    check("R7 flags", {6'd0, faultDown, faultUp}, {6'd0, mFlagB, mFlagA});
  endtask

  task automatic doReset(input int mode, input int a, input int b);
    @(negedge clk);
    rstN = 1'b0;
    enable = 1'b0;
    fMode = mode; fA = a; fB = b;
    @(negedge clk);
    @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic runAll();
    logic [7:0] seen0;
    logic [7:0] seen1;
    logic [7:0] held;

    // R1: reset state
    @(negedge clk);
    check("R1 reset netTx", netTx, 8'h78);
    check("R1 reset flags", {6'd0, faultDown, faultUp}, 8'd0);

    // Clean loopback: R10 toggling, no flags
    doReset(0, 0, 1);
    enable = 1'b1;
    seen0 = '0; seen1 = '0;
    for (int k = 0; k < 12; k++) begin
      cycle();
      seen0 |= ~netTx;
      seen1 |= netTx;
    end
    check("R10 saw zero", seen0, 8'hFF);
    check("R10 saw one", seen1, 8'hFF);
    check("R7 clean run flags", {6'd0, faultDown, faultUp}, 8'd0);

    // R6: net 3 stuck-0 mismatches at up=0 only on the first edge
    doReset(1, 3, 0);
    enable = 1'b1;
    cycle();
    check("R6 first edge ignored", {7'd0, faultUp}, 8'd0);
    cycle();
    cycle();
    cycle();
    check("R7 lane A stuck net3", {7'd0, faultUp}, 8'd1);

    // R9: enable low holds bundle and flags despite a fault
    doReset(2, 4, 0);
    enable = 1'b1;
    cycle();
    enable = 1'b0;
    held = netTx;
    for (int k = 0; k < 4; k++) cycle();
    check("R9 netTx held", netTx, held);
    check("R9 flags held", {6'd0, faultDown, faultUp}, 8'd0);
    enable = 1'b1;
    for (int k = 0; k < 4; k++) cycle();
    check("R7 lane B stuck net4", {7'd0, faultDown}, 8'd1);

    // R8: remove the fault, flag remains
    fMode = 0;
    for (int k = 0; k < 6; k++) cycle();
    check("R8 sticky after clear", {7'd0, faultDown}, 8'd1);

    // Stuck-at on every net must raise some flag (R7)
    for (int n = 0; n < 8; n++) begin
      for (int s = 1; s <= 2; s++) begin
        doReset(s, n, 0);
        enable = 1'b1;
        for (int k = 0; k < 6; k++) cycle();
        check($sformatf("R7 stuck%0d net%0d detected", s - 1, n),
              {7'd0, faultUp | faultDown}, 8'd1);
      end
    end

    // Shorts between every pair, compared with the model each cycle (R7)
    for (int a = 0; a < 8; a++) begin
      for (int b = a + 1; b < 8; b++) begin
        for (int m = 3; m <= 4; m++) begin
          doReset(m, a, b);
          enable = 1'b1;
          for (int k = 0; k < 6; k++) cycle();
        end
      end
    end
  endtask

  initial begin
    fork
      begin
        runAll();
      end
      begin
        repeat (100000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog R1 actual=timeout expected=complete");
      end
    join_any
    disable fork;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule